// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port for a system-clock domain. It serializes bytes from a valid/ready transmit interface onto a single output line. It also deserializes the incoming line into bytes that appear on a valid/ready receive interface. Each received byte carries its own parity-error and framing-error flags.

The frame format is chosen at run time from four inputs: character length (7 or 8 bits), stop-bit count (1 or 2), parity mode (none, odd, even, mark, space) and a baud divisor. The divisor produces a 16x oversampling tick, so the bit rate is the clock rate divided by 16·(divisor+1). This covers rates from a few hundred baud to several Mbaud at common clock rates. The block captures the configuration only while both directions are idle, so a frame that is already on the line always finishes in the format it started with.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, `txd_o` is high, `tx_ready_o` is high and `rx_valid_o` is low.
- R2: A transmitted frame has these parts in order: one low start bit, the data bits LSB first (7 when `cfg_len8_i`=0, 8 when 1), an optional parity bit, and then one high stop bit, or two when `cfg_stop2_i`=1. Each bit lasts 16·(`cfg_div_i`+1) clocks, and the line idles high.
- R3: The `cfg_parity_i` codes are 0 none, 1 odd, 2 even, 3 mark and 4 space; codes 5 to 7 act as none. Odd parity makes the number of ones in the data plus the parity bit odd, and even parity makes it even. Mark sends 1 and space sends 0. In 7-bit mode only the 7 sent data bits count toward parity.
- R4: A byte is accepted on a clock where `tx_valid_i` and `tx_ready_o` are both high. From the next clock, `txd_o` is low (start bit) and `tx_ready_o` stays low until the last stop bit has been sent.
- R5: The receiver returns the data bits LSB first in `rx_data_o`. In 7-bit mode, bit 7 is returned as 0.
- R6: `rx_par_err_o` is set with a byte whose received parity bit differs from the bit the configured mode expects.
- R7: `rx_frm_err_o` is set with a byte when any of its stop bits is sampled low; with two stop bits, either one counts.
- R8: With parity set to none, no parity bit is expected and `rx_par_err_o` stays low.
- R9: `rx_valid_o` stays high until the clock where `rx_ready_i` is high, and is low on the following clock. A byte that completes while the previous one is still unconsumed replaces it.
- R10: A low pulse on `rxd_i` shorter than half a bit period does not start a reception.
- R11: Configuration inputs take effect only while both directions are idle and `tx_valid_i` is low. A change made during a frame does not alter that frame.
- R12: The oversampling tick repeats every `cfg_div_i`+1 clocks, so the start bit's low time lies between 16·(`cfg_div_i`+1) − (`cfg_div_i`+1) and 16·(`cfg_div_i`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2_i | input | 1 | 1: two stop bits, 0: one |
| cfg_parity_i | input | 3 | Parity mode code (see R3) |
| cfg_div_i | input | DIV_W | Baud divisor; tick every value+1 clocks |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter idle, byte can be taken |
| txd_o | output | 1 | Serial output line |
| rxd_i | input | 1 | Serial input line (asynchronous) |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| rx_par_err_o | output | 1 | Parity error for the byte shown |
| rx_frm_err_o | output | 1 | Framing error for the byte shown |

## Verification
The start bit appears on `txd_o` one clock after acceptance, so the bench finds the falling edge and samples each bit half a period later, then once per bit period. This is the centre of each bit even with the up-to-one-tick start jitter. A received byte is delivered mid-way through its last stop bit, plus two synchronizer clocks. The bench therefore checks the receive outputs four clocks after it has driven the whole frame, which is well after delivery and before any later event. `rx_valid_o` is checked one clock after `rx_ready_i` is pulsed. Configuration is applied two clocks before any stimulus so that the idle-time capture has taken place.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  typedef struct packed {
    logic       len8;
    logic       stop2;
    logic [2:0] par;
  } fmt_t;

  function automatic logic par_on(logic [2:0] mode);
    return (mode >= 3'd1) && (mode <= 3'd4);
  endfunction

  // data must already be masked to the active length
  function automatic logic par_bit(logic [7:0] d, logic [2:0] mode);
    unique case (mode)
      PAR_ODD:  return ~^d;
      PAR_EVEN: return ^d;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o); // R12

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  fmt_t       fmt_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       busy_o,
  output logic       txd_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;

  tx_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       idx_q;
  logic [7:0]       sh_q;
  logic             par_q;
  logic             stop_q;
  logic [7:0]       d_msk;
  logic [2:0]       idx_last;

  assign d_msk    = fmt_i.len8 ? data_i : {1'b0, data_i[6:0]};
  assign idx_last = fmt_i.len8 ? 3'd7 : 3'd6;
  assign ready_o  = (st_q == TX_IDLE);
  assign busy_o   = (st_q != TX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (st_q == TX_IDLE) begin
      if (valid_i) begin
        sh_q   <= d_msk;
        par_q  <= par_bit(d_msk, fmt_i.par);
        st_q   <= TX_START;
        cnt_q  <= '0;
        idx_q  <= '0;
        stop_q <= 1'b0;
      end
    end else if (tick_i) begin
      if (cnt_q != CNT_LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        unique case (st_q)
          TX_START: st_q <= TX_DATA;
          TX_DATA: begin
            if (idx_q == idx_last) st_q <= par_on(fmt_i.par) ? TX_PAR : TX_STOP;
            else idx_q <= idx_q + 1'b1;
          end
          TX_PAR: st_q <= TX_STOP;
          TX_STOP: begin
            if (fmt_i.stop2 && !stop_q) stop_q <= 1'b1;
            else st_q <= TX_IDLE;
          end
          default: st_q <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = sh_q[idx_q];
      TX_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  AST_TX_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!ready_o && !txd_o)); // R4
  AST_TX_END_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> txd_o); // R2

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  fmt_t       fmt_i,
  input  logic       rxd_i,
  output logic [7:0] data_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       valid_o,
  input  logic       ready_i,
  output logic       busy_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

  rx_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       idx_q;
  logic [7:0]       buf_q;
  logic             par_bad_q;
  logic             frm_bad_q;
  logic             stop_q;
  logic             s1_q, s2_q;
  logic [2:0]       idx_last;

  assign idx_last = fmt_i.len8 ? 3'd7 : 3'd6;
  assign busy_o   = (st_q != RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      buf_q     <= '0;
      par_bad_q <= 1'b0;
      frm_bad_q <= 1'b0;
      stop_q    <= 1'b0;
      data_o    <= '0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            if (!s2_q) begin
              st_q      <= RX_START;
              cnt_q     <= '0;
              idx_q     <= '0;
              buf_q     <= '0;
              par_bad_q <= 1'b0;
              frm_bad_q <= 1'b0;
              stop_q    <= 1'b0;
            end
          end
          RX_START: begin
            // confirm start at mid-bit, else treat as glitch
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              st_q  <= s2_q ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q        <= '0;
              buf_q[idx_q] <= s2_q;
              if (idx_q == idx_last) st_q <= par_on(fmt_i.par) ? RX_PAR : RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_PAR: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q     <= '0;
              par_bad_q <= (s2_q != par_bit(buf_q, fmt_i.par));
              st_q      <= RX_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              if (fmt_i.stop2 && !stop_q) begin
                stop_q    <= 1'b1;
                frm_bad_q <= frm_bad_q | !s2_q;
              end else begin
                data_o    <= buf_q;
                par_err_o <= par_bad_q;
                frm_err_o <= frm_bad_q | !s2_q;
                valid_o   <= 1'b1;
                st_q      <= RX_IDLE;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o); // R9
  AST_RX_NOPAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(valid_o) && !par_on(fmt_i.par)) |-> !par_err_o); // R8
  AST_RX_MSB7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(valid_o) && !fmt_i.len8) |-> !data_o[7]); // R5

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_len8_i,
  input  logic             cfg_stop2_i,
  input  logic [2:0]       cfg_parity_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic             txd_o,
  input  logic             rxd_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             rx_par_err_o,
  output logic             rx_frm_err_o
);
  fmt_t             fmt_q;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             tx_busy, rx_busy;
  logic             cfg_upd;

  // capture only with both sides idle and no byte being offered
  assign cfg_upd = !tx_busy && !rx_busy && !tx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q <= '{len8: 1'b1, stop2: 1'b0, par: PAR_NONE};
      div_q <= '0;
    end else if (cfg_upd) begin
      fmt_q <= '{len8: cfg_len8_i, stop2: cfg_stop2_i, par: cfg_parity_i};
      div_q <= cfg_div_i;
    end
  end

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .tick_o (tick)
  );

  uart_tx #(.OSR(OSR)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .fmt_i   (fmt_q),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .busy_o  (tx_busy),
    .txd_o   (txd_o)
  );

  uart_rx #(.OSR(OSR)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .fmt_i     (fmt_q),
    .rxd_i     (rxd_i),
    .data_o    (rx_data_o),
    .par_err_o (rx_par_err_o),
    .frm_err_o (rx_frm_err_o),
    .valid_o   (rx_valid_o),
    .ready_i   (rx_ready_i),
    .busy_o    (rx_busy)
  );

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy || rx_busy) |=> ($stable(fmt_q) && $stable(div_q))); // R11

endmodule

// File: tb/sim_uart_xcvr.sv
module sim_uart_xcvr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len8 = 1'b1, stop2 = 1'b0;
  logic [2:0]  pm = 3'd0;
  logic [15:0] div = 16'd3;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, txd;
  logic        rxd = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_ready = 1'b0, rx_perr, rx_ferr;
  int          checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  uart_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_len8_i(len8), .cfg_stop2_i(stop2),
    .cfg_parity_i(pm), .cfg_div_i(div), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .txd_o(txd), .rxd_i(rxd), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_par_err_o(rx_perr),
    .rx_frm_err_o(rx_ferr)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic pon(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  function automatic logic pbit(input logic [7:0] d, input logic [2:0] m);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (m)
      3'd1: return (ones % 2 == 0);
      3'd2: return (ones % 2 == 1);
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // bit 0 = start bit
  task automatic build(input logic [7:0] d, input logic l8, input logic s2, input logic [2:0] m,
                       output logic [11:0] bits, output int n);
    logic [7:0] dm;
    dm = l8 ? d : {1'b0, d[6:0]};
    bits = '1;
    n = 0;
    bits[n] = 1'b0; n = n + 1;
    for (int i = 0; i < (l8 ? 8 : 7); i++) begin bits[n] = dm[i]; n = n + 1; end
    if (pon(m)) begin bits[n] = pbit(dm, m); n = n + 1; end
    bits[n] = 1'b1; n = n + 1;
    if (s2) begin bits[n] = 1'b1; n = n + 1; end
  endtask

  task automatic set_cfg(input logic l8, input logic s2, input logic [2:0] m, input logic [15:0] dv);
    @(negedge clk);
    len8 = l8; stop2 = s2; pm = m; div = dv;
    repeat (2) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic chg, input string tag);
    logic [11:0] exp, got;
    int n, p, w;
    logic l8s, s2s;
    logic [2:0] ms;
    logic [15:0] dvs;
    l8s = len8; s2s = stop2; ms = pm; dvs = div;
    build(d, len8, stop2, pm, exp, n);
    p = 16 * (int'(div) + 1);
    got = '1;
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(posedge clk);
    #1 tx_valid = 1'b0;
    w = 0;
    while (txd !== 1'b0 && w < 2 * p) begin @(negedge clk); w++; end
    repeat (p / 2) @(negedge clk);
    got[0] = txd;
    chk(tx_ready == 1'b0, "R4 ready low during frame", tx_ready, 0);
    for (int k = 1; k < n; k++) begin
      if (chg && k == 2) begin
        len8 = ~len8; stop2 = ~stop2; pm = (pm == 3'd1) ? 3'd2 : 3'd1; div = div + 16'd1;
      end
      repeat (p) @(negedge clk);
      got[k] = txd;
    end
    chk(got == exp, tag, got, exp);
    w = 0;
    while (tx_ready !== 1'b1 && w < 2 * p) begin @(negedge clk); w++; end
    chk(tx_ready == 1'b1 && txd == 1'b1, "R4 ready back, line idle high", {tx_ready, txd}, 2'b11);
    if (chg) set_cfg(l8s, s2s, ms, dvs);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic flip, input int slow, input string tag);
    logic [11:0] bits;
    int n, p, nd;
    logic [7:0] exp;
    build(d, len8, stop2, pm, bits, n);
    nd = len8 ? 8 : 7;
    if (flip && pon(pm)) bits[1 + nd] = ~bits[1 + nd];
    if (slow >= 0) bits[1 + nd + int'(pon(pm)) + slow] = 1'b0;
    p = 16 * (int'(div) + 1);
    for (int k = 0; k < n; k++) begin
      rxd = bits[k];
      repeat (p) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    exp = len8 ? d : {1'b0, d[6:0]};
    chk(rx_valid == 1'b1, {tag, " valid"}, rx_valid, 1);
    chk(rx_data == exp, {tag, " data"}, rx_data, exp);
    chk(rx_perr == (flip && pon(pm)), {tag, " parity flag R6 R8"}, rx_perr, flip && pon(pm));
    chk(rx_ferr == (slow >= 0), {tag, " framing flag R7"}, rx_ferr, slow >= 0);
  endtask

  task automatic consume();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R9 valid cleared after ready", rx_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int fall, rise, p, seed;
    seed = int'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1 && tx_ready == 1 && rx_valid == 0, "R1 reset state",
        {txd, tx_ready, rx_valid}, 3'b110);

    // directed transmit cases
    set_cfg(1'b1, 1'b0, 3'd1, 16'd3);
    tx_frame(8'hA5, 1'b0, "R2 R3 tx 8N1 odd");
    set_cfg(1'b0, 1'b1, 3'd3, 16'd2);
    tx_frame(8'hFF, 1'b0, "R2 R3 tx 7-bit mark 2 stop");
    set_cfg(1'b1, 1'b1, 3'd4, 16'd1);
    tx_frame(8'h3C, 1'b0, "R3 tx space");
    set_cfg(1'b1, 1'b0, 3'd2, 16'd3);
    tx_frame(8'h81, 1'b1, "R11 tx cfg change mid-frame ignored");

    // R12: start bit low time
    set_cfg(1'b1, 1'b0, 3'd0, 16'd5);
    p = 16 * 6;
    @(negedge clk); tx_data = 8'h01; tx_valid = 1'b1;
    @(posedge clk); #1 tx_valid = 1'b0;
    fall = cycles;
    while (txd !== 1'b0) @(posedge clk);
    fall = cycles;
    while (txd !== 1'b1 && cycles - fall < 2 * p) @(posedge clk);
    rise = cycles;
    chk((rise - fall) <= p && (rise - fall) >= p - 6, "R12 bit period", rise - fall, p);
    while (tx_ready !== 1'b1) @(negedge clk);

    // directed receive cases
    set_cfg(1'b1, 1'b0, 3'd2, 16'd3);
    rx_frame(8'h5A, 1'b0, -1, "R5 rx 8E1");
    consume();
    rx_frame(8'h5B, 1'b1, -1, "R6 rx parity flipped");
    consume();
    set_cfg(1'b0, 1'b0, 3'd1, 16'd3);
    rx_frame(8'hC3, 1'b0, -1, "R5 rx 7-bit msb zero");
    consume();
    set_cfg(1'b1, 1'b1, 3'd0, 16'd3);
    rx_frame(8'h77, 1'b0, 0, "R7 rx first stop low");
    consume();
    repeat (200) @(negedge clk);
    rx_frame(8'h11, 1'b0, 1, "R7 rx second stop low");
    consume();
    repeat (200) @(negedge clk);
    set_cfg(1'b1, 1'b0, 3'd0, 16'd3);
    rx_frame(8'h96, 1'b1, -1, "R8 rx no parity flip ignored");
    // R9: second byte overwrites unconsumed first
    rx_frame(8'h4E, 1'b0, -1, "R9 rx overwrite");
    consume();
    // R10: short glitch rejected
    @(negedge clk) rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (128) @(negedge clk);
    chk(rx_valid == 1'b0, "R10 glitch rejected", rx_valid, 0);
    rx_frame(8'hE7, 1'b0, -1, "R10 rx after glitch");
    consume();

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic l8, s2, fl;
      logic [2:0] m;
      logic [15:0] dv;
      logic [7:0] d;
      l8 = 1'($urandom % 2); s2 = 1'($urandom % 2);
      m = 3'($urandom % 5); dv = 16'(1 + $urandom % 3);
      d = 8'($urandom); fl = ($urandom % 4) == 0;
      set_cfg(l8, s2, m, dv);
      tx_frame(d, 1'b0, "R2 R3 random tx");
      d = 8'($urandom);
      rx_frame(d, fl, -1, "R5 random rx");
      consume();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule